// File: doc/BRIEF.md
# Last Branch and Exception Recorder

This block keeps a small history of control flow for debugging. A stream of control-transfer events enters it, each event carrying the code-segment offset it leaves from, the offset it lands on, and a two-bit kind: ordinary branch, interrupt, exception or debug exception. While software has set the recording flag, each branch, interrupt or exception overwrites the last-transfer pair. An interrupt or exception also first copies the pair it replaces into a second pair of pre-trap registers. The handler can then see both the trap itself and the branch that ran just before it. The stored values are segment offsets, not linear addresses.

When a debug exception arrives, the block drops the recording flag and leaves all four address registers as they were. The history stays frozen while the debug handler reads it through a combinational four-way read port. Recording starts again only when software writes the flag back to one. A two-state controller holds the flag. OFF (flag clear) moves to REC when software writes a one; this transition is named *arm*. REC moves back to OFF either on a debug exception (*freeze*) or when software writes a zero (*disarm*). Every other cycle keeps the current state.

Top module: `lbx_recorder`

## Requirements
- R1: After reset, the recording flag `rec_en` is 0 and all four address registers read 0.
- R2: A cycle with `en_wr`=1 sets the flag to `en_wdata` from the next cycle on, unless a debug freeze happens in that same cycle (R7).
- R3: When the flag is 1 and an event with `evt_kind`=2'b00 (branch) is valid, the next cycle the last-transfer source reads `evt_from` and the last-transfer target reads `evt_to`, and the pre-trap pair is unchanged.
- R4: When the flag is 1 and an event with `evt_kind`=2'b01 (interrupt) or 2'b10 (exception) is valid, the next cycle the pre-trap pair holds the last-transfer pair as it was before the event, and the last-transfer pair holds the event's offsets.
- R5: When the flag is 1 and an event with `evt_kind`=2'b11 (debug exception) is valid, the flag is 0 the next cycle and none of the four registers changes. The debug event itself is not recorded.
- R6: When the flag is 0, valid events of every kind leave all four registers unchanged.
- R7: A debug freeze wins over a software write of 1 in the same cycle. An event in the same cycle as a software write is judged by the flag value from before that write.
- R8: `rd_data` shows, in the same cycle, the register picked by `rd_sel`: 0 last-transfer source, 1 last-transfer target, 2 pre-trap source, 3 pre-trap target.
- R9: After a freeze, recording resumes once software writes the flag to 1, and the next branch is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A control-transfer event is present this cycle |
| evt_kind | input | 2 | 00 branch, 01 interrupt, 10 exception, 11 debug exception |
| evt_from | input | ADDR_W | Source offset of the transfer |
| evt_to | input | ADDR_W | Target offset of the transfer |
| en_wr | input | 1 | Software write strobe for the recording flag |
| en_wdata | input | 1 | Value written to the recording flag |
| rd_sel | input | 2 | Selects which address register drives `rd_data` |
| rd_data | output | ADDR_W | Selected address register |
| rec_en | output | 1 | Current recording flag |

## Verification
The bench builds the block with the default `ADDR_W` of 32. Distinct 32-bit offsets with high bits set then show any bit lost when one register is copied into another. With only four registers and two states, the bench can reach every transition and every event kind in both states within a few dozen cycles. This includes a debug event that coincides with a software write, and a write of 1 that coincides with an event while the flag is still clear.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);

    // register slots, in read-select order
    localparam int SLOT_BF = 0;
    localparam int SLOT_BT = 1;
    localparam int SLOT_EF = 2;
    localparam int SLOT_ET = 3;

    typedef enum logic [1:0] {
        EV_BRANCH = 2'b00,
        EV_INTR   = 2'b01,
        EV_EXC    = 2'b10,
        EV_DEBUG  = 2'b11
    } ev_kind_t;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_REC = 1'b1
    } rec_state_t;

endpackage

// File: rtl/lbx_event_decode.sv
module lbx_event_decode
    import lbx_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] kind,
    input  logic       armed,
    output logic       br_ld,
    output logic       ex_ld,
    output logic       freeze
);

    ev_kind_t kind_e;
    logic     live;

    assign kind_e = ev_kind_t'(kind);
    assign live   = valid && armed;

    always_comb begin
        br_ld  = 1'b0;
        ex_ld  = 1'b0;
        freeze = 1'b0;
        unique case (kind_e)
            EV_BRANCH: br_ld  = live;
            EV_INTR,
            EV_EXC:    ex_ld  = live;
            EV_DEBUG:  freeze = live;
        endcase
    end

endmodule

// File: rtl/lbx_ctrl.sv
module lbx_ctrl
    import lbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic en_wr,
    input  logic en_wdata,
    output logic armed
);

    rec_state_t state_q;
    rec_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_wr && en_wdata) begin
                    state_d = ST_REC;              // arm
                end
            end
            ST_REC: begin
                if (freeze) begin
                    state_d = ST_OFF;              // freeze, wins over a write
                end else if (en_wr && !en_wdata) begin
                    state_d = ST_OFF;              // disarm
                end
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_OFF: armed = 1'b0;
            ST_REC: armed = 1'b1;
        endcase
    end

endmodule

// File: rtl/lbx_regfile.sv
module lbx_regfile
    import lbx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_ld,
    input  logic              ex_ld,
    input  logic [ADDR_W-1:0] from_i,
    input  logic [ADDR_W-1:0] to_i,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    output logic [ADDR_W-1:0] slot_o [NUM_REGS]
);

    logic [ADDR_W-1:0] slot_q [NUM_REGS];
    logic              pair_ld;

    assign pair_ld = br_ld || ex_ld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            if (ex_ld) begin
                slot_q[SLOT_EF] <= slot_q[SLOT_BF];
                slot_q[SLOT_ET] <= slot_q[SLOT_BT];
            end
            if (pair_ld) begin
                slot_q[SLOT_BF] <= from_i;
                slot_q[SLOT_BT] <= to_i;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_out
            assign slot_o[g] = slot_q[g];
        end
    endgenerate

    assign rd_data = slot_q[rd_sel];

endmodule

// File: rtl/lbx_recorder.sv
module lbx_recorder
    import lbx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [1:0]           evt_kind,
    input  logic [ADDR_W-1:0]    evt_from,
    input  logic [ADDR_W-1:0]    evt_to,
    input  logic                 en_wr,
    input  logic                 en_wdata,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [ADDR_W-1:0]    rd_data,
    output logic                 rec_en
);

    logic              armed;
    logic              br_ld;
    logic              ex_ld;
    logic              freeze;
    logic [ADDR_W-1:0] slot [NUM_REGS];
    logic [ADDR_W-1:0] mon_bf;
    logic [ADDR_W-1:0] mon_bt;
    logic [ADDR_W-1:0] mon_ef;
    logic [ADDR_W-1:0] mon_et;

    lbx_event_decode u_dec (
        .valid  (evt_valid),
        .kind   (evt_kind),
        .armed  (armed),
        .br_ld  (br_ld),
        .ex_ld  (ex_ld),
        .freeze (freeze)
    );

    lbx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (freeze),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .armed    (armed)
    );

    lbx_regfile #(.ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .br_ld   (br_ld),
        .ex_ld   (ex_ld),
        .from_i  (evt_from),
        .to_i    (evt_to),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .slot_o  (slot)
    );

    assign rec_en = armed;
    assign mon_bf = slot[SLOT_BF];
    assign mon_bt = slot[SLOT_BT];
    assign mon_ef = slot[SLOT_EF];
    assign mon_et = slot[SLOT_ET];

endmodule

// File: rtl/lbx_recorder_chk.sv
module lbx_recorder_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [1:0]        evt_kind,
    input logic [ADDR_W-1:0] evt_from,
    input logic [ADDR_W-1:0] evt_to,
    input logic              en_wr,
    input logic              en_wdata,
    input logic              rec_en,
    input logic [ADDR_W-1:0] mon_bf,
    input logic [ADDR_W-1:0] mon_bt,
    input logic [ADDR_W-1:0] mon_ef,
    input logic [ADDR_W-1:0] mon_et
);

    logic dbg_hit;
    assign dbg_hit = rec_en && evt_valid && (evt_kind == 2'b11);

    assert_sw_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !dbg_hit) |=> (rec_en == $past(en_wdata)));

    assert_branch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_en && evt_valid && evt_kind == 2'b00) |=>
        (mon_bf == $past(evt_from) && mon_bt == $past(evt_to)
         && $stable(mon_ef) && $stable(mon_et)));

    assert_trap_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_en && evt_valid && (evt_kind == 2'b01 || evt_kind == 2'b10)) |=>
        (mon_ef == $past(mon_bf) && mon_et == $past(mon_bt)
         && mon_bf == $past(evt_from) && mon_bt == $past(evt_to)));

    assert_debug_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_hit |=> (!rec_en && $stable(mon_bf) && $stable(mon_bt)
                     && $stable(mon_ef) && $stable(mon_et)));

    assert_ignore_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> ($stable(mon_bf) && $stable(mon_bt)
                     && $stable(mon_ef) && $stable(mon_et)));

    assert_freeze_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_hit && en_wr && en_wdata) |=> !rec_en);

endmodule

bind lbx_recorder lbx_recorder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .evt_from  (evt_from),
    .evt_to    (evt_to),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .rec_en    (rec_en),
    .mon_bf    (mon_bf),
    .mon_bt    (mon_bt),
    .mon_ef    (mon_ef),
    .mon_et    (mon_et)
);

// File: tb/lbx_recorder_tb.sv
module lbx_recorder_tb;

    localparam int AW = 32;

    typedef struct {
        int          sel;       // 0..3 register, 4 = flag
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_valid = 1'b0;
    logic [1:0]    evt_kind = 2'b00;
    logic [AW-1:0] evt_from = '0;
    logic [AW-1:0] evt_to = '0;
    logic          en_wr = 1'b0;
    logic          en_wdata = 1'b0;
    logic [1:0]    rd_sel = 2'd0;
    logic [AW-1:0] rd_data;
    logic          rec_en;

    item_t q[$];
    event  smp;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // spec model
    logic [31:0] m_reg [4];
    logic        m_en;

    always #10 clk = ~clk;

    lbx_recorder #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_from(evt_from), .evt_to(evt_to), .en_wr(en_wr), .en_wdata(en_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data), .rec_en(rec_en)
    );

    // monitor: pops expectations and compares
    always @(smp) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = (it.sel == 4) ? {31'd0, rec_en} : rd_data;
        n_cmp++;
        if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
    end

    task automatic step(input bit v, input logic [1:0] k, input logic [31:0] f,
                        input logic [31:0] t, input bit w, input bit d);
        bit hit;
        @(negedge clk);
        evt_valid = v; evt_kind = k; evt_from = f; evt_to = t;
        en_wr = w; en_wdata = d;
        hit = v && m_en;
        if (hit && k == 2'b00) begin
            m_reg[0] = f; m_reg[1] = t;
        end else if (hit && (k == 2'b01 || k == 2'b10)) begin
            m_reg[2] = m_reg[0]; m_reg[3] = m_reg[1];
            m_reg[0] = f; m_reg[1] = t;
        end
        if (hit && k == 2'b11) m_en = 1'b0;
        else if (w) m_en = d;
        @(posedge clk);
        #1;
        evt_valid = 1'b0; en_wr = 1'b0;
    endtask

    task automatic verify(input string tag);
        @(negedge clk);
        for (int s = 0; s < 5; s++) begin
            item_t it;
            if (s < 4) rd_sel = s[1:0];
            #1;
            it.sel = s;
            it.exp = (s == 4) ? {31'd0, m_en} : m_reg[s];
            it.tag = tag;
            q.push_back(it);
            ->smp;
            #1;
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        verify("R1 reset state");

        step(1, 2'b00, 32'h1111_0001, 32'h2222_0001, 0, 0);
        verify("R6 branch ignored while off");

        step(0, 2'b00, 0, 0, 1, 1);
        verify("R2 flag set by write");

        step(1, 2'b00, 32'hA000_0010, 32'hA000_0200, 0, 0);
        verify("R3 first branch");
        step(1, 2'b00, 32'hB000_0030, 32'hB000_0400, 0, 0);
        verify("R3 second branch keeps trap pair");

        step(1, 2'b01, 32'hC000_0050, 32'hC0DE_0000, 0, 0);
        verify("R4 interrupt saves prior branch");
        step(1, 2'b10, 32'hD000_0070, 32'hDEAD_0000, 0, 0);
        verify("R4 exception saves prior transfer");

        step(1, 2'b11, 32'hEEEE_0001, 32'hEEEE_0002, 0, 0);
        verify("R5 debug freeze");

        step(1, 2'b00, 32'h5555_0001, 32'h5555_0002, 0, 0);
        verify("R6 branch after freeze ignored");
        step(1, 2'b10, 32'h6666_0001, 32'h6666_0002, 0, 0);
        verify("R6 exception while off ignored");

        step(1, 2'b00, 32'h7777_0001, 32'h7777_0002, 1, 1);
        verify("R7 event with arming write uses old flag");
        step(1, 2'b11, 32'h8888_0001, 32'h8888_0002, 1, 1);
        verify("R7 freeze beats write of one");

        step(0, 2'b00, 0, 0, 1, 1);
        step(1, 2'b00, 32'h9999_0100, 32'h9999_0200, 0, 0);
        verify("R9 recording resumes after re-arm");

        // R8: sweep select inside one cycle, no clock edge between reads
        @(negedge clk);
        for (int s = 3; s >= 0; s--) begin
            item_t it;
            rd_sel = s[1:0];
            #1;
            it.sel = s; it.exp = m_reg[s]; it.tag = "R8 combinational select";
            q.push_back(it);
            ->smp;
            #1;
        end

        step(0, 2'b00, 0, 0, 1, 0);
        verify("R2 flag cleared by write");
        step(1, 2'b01, 32'hABCD_0001, 32'hABCD_0002, 0, 0);
        verify("R6 interrupt after disarm ignored");

        #5;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule